// File: doc/BRIEF.md
# Time-Domain SAR Azimuth Compressor

This block forms one focused image line per radar pulse. It uses time-domain correlation in the along-track direction and works on data that has already been range-compressed. Pulses arrive as lines of complex range-cell samples. They are stored in a circular buffer that keeps the newest `BMAX` lines. Once that buffer is full, every new line starts a synthesis pass.

For each output cell `l`, a pass adds up `BMAX` terms, one for each aperture position `b`. Each term is read from line `m-b` at the range cell `l + off(l,b)`, which follows the migration curve. It is then rotated by a phase-correction phasor `cos + j·sin` before it is added.

A host loads the migration offsets and the phasors into internal tables through a simple write port. The image line leaves the block as a stream of `NCELLS` complex beats, with a marker on the last beat.

Top module: `sar_az_compressor`

## Requirements
- R1: After reset or after `flush`, no output beat is produced until `BMAX` complete input lines have been accepted. Every complete line accepted after that produces one output line.
- R2: Output cell `l` equals the sum over b=0..BMAX-1 of x(m-b, l+off(l,b)) · (cos(l,b) + j·sin(l,b)). Here m is the newest line, `off` is a signed table entry, and table entry (l,b) is written with `tbl_cell`=l and `tbl_ap`=b.
- R3: A term whose migrated index l+off(l,b) is below 0 or above NCELLS-1 contributes zero.
- R4: Each complex product is re = xr·c − xi·s and im = xr·s + xi·c. The phasors are in Q1.15. The terms are summed at full precision, and the output is the sum arithmetically shifted right by `SHIFT` (default 15).
- R5: Aperture index b reads the line received b lines before the newest one. The window slides by one line for each new input line.
- R6: An output line is exactly NCELLS beats in cell order 0..NCELLS-1, and `out_last` is high only on the beat for cell NCELLS-1.
- R7: `in_ready` is low from the acceptance of a line's final sample until the last beat of that line's output. Samples offered during that time are not consumed.
- R8: A sample accepted with `in_sol` high is written to cell 0. Later samples fill the following cells, and the line is complete when cell NCELLS-1 is written.
- R9: `flush` clears the line count and the write position, so warm-up (R1) starts over.
- R10: After reset, `in_ready` is 1 and `out_valid` and `out_last` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Restart warm-up and the line position |
| tbl_we | input | 1 | Table write strobe |
| tbl_cell | input | $clog2(NCELLS) | Table range-cell index l |
| tbl_ap | input | $clog2(BMAX) | Table aperture index b |
| tbl_off | input | OFFW | Signed migration offset |
| tbl_cos | input | PW | Phasor real part, Q1.15 |
| tbl_sin | input | PW | Phasor imaginary part, Q1.15 |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can accept a sample |
| in_sol | input | 1 | Sample is range cell 0 of a line |
| in_re | input | DW | Input sample real part |
| in_im | input | DW | Input sample imaginary part |
| out_valid | output | 1 | Output beat valid |
| out_last | output | 1 | Beat is the final cell of the line |
| out_re | output | DW+PW+2+$clog2(BMAX)-SHIFT | Output real part |
| out_im | output | DW+PW+2+$clog2(BMAX)-SHIFT | Output imaginary part |

## Verification
The assertions assume that `flush` is never raised in the same cycle as an input handshake. They also assume the tables are only written while no synthesis pass is running. The bench loads the tables once, before any line is sent, and raises `flush` only while the input is idle. It also keeps `in_valid` asserted through each synthesis pass, so back-pressure is actually tested. The stimulus places a point echo on a different cell for each pulse. The migration table makes the edge apertures step one cell outward, which pushes some indices outside the line at both ends.

// File: rtl/sar_az_compressor.sv
module sar_az_compressor #(
  parameter int NCELLS = 8,
  parameter int BMAX   = 4,
  parameter int DW     = 16,
  parameter int PW     = 16,
  parameter int OFFW   = 4,
  parameter int SHIFT  = 15,
  localparam int CW = $clog2(NCELLS),
  localparam int BW = $clog2(BMAX),
  localparam int AW = DW + PW + 2 + BW,
  localparam int OW = AW - SHIFT
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush,
  input  logic                 tbl_we,
  input  logic [CW-1:0]        tbl_cell,
  input  logic [BW-1:0]        tbl_ap,
  input  logic signed [OFFW-1:0] tbl_off,
  input  logic signed [PW-1:0] tbl_cos,
  input  logic signed [PW-1:0] tbl_sin,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic                 in_sol,
  input  logic signed [DW-1:0] in_re,
  input  logic signed [DW-1:0] in_im,
  output logic                 out_valid,
  output logic                 out_last,
  output logic signed [OW-1:0] out_re,
  output logic signed [OW-1:0] out_im
);
  localparam int NT = NCELLS * BMAX;
  localparam int TW = $clog2(NT);

  logic signed [DW-1:0]   lb_re [NT];
  logic signed [DW-1:0]   lb_im [NT];
  logic signed [OFFW-1:0] off_t [NT];
  logic signed [PW-1:0]   cos_t [NT];
  logic signed [PW-1:0]   sin_t [NT];

  logic          busy;
  logic [CW-1:0] col, l_i;
  logic [BW-1:0] wptr, b_i;
  logic [BW:0]   fill;
  logic signed [AW-1:0] acc_re, acc_im;

  assign in_ready = !busy;

  wire           take  = in_valid && !busy && !flush;
  wire [CW-1:0]  wcol  = in_sol ? '0 : col;
  wire [BW-1:0]  wnext = (wptr == BW'(BMAX - 1)) ? '0 : wptr + 1'b1;
  wire [TW-1:0]  waddr = TW'(wptr * NCELLS + wcol);

  wire [TW-1:0]  tix = TW'(l_i * BMAX + b_i);
  logic signed [31:0] idx;
  assign idx = 32'($signed({1'b0, l_i})) + 32'(off_t[tix]);
  wire           inr = (idx >= 0) && (idx < NCELLS);
  wire [BW-1:0]  rline = (wptr >= b_i) ? wptr - b_i
                       : BW'({1'b0, wptr} + (BW+1)'(BMAX) - {1'b0, b_i});
  wire [TW-1:0]  raddr = TW'(rline * NCELLS + idx[CW-1:0]);

  wire signed [DW-1:0] xr = inr ? lb_re[raddr] : '0;
  wire signed [DW-1:0] xi = inr ? lb_im[raddr] : '0;
  wire signed [PW-1:0] pc = cos_t[tix];
  wire signed [PW-1:0] ps = sin_t[tix];

  logic signed [DW+PW-1:0] p_rc, p_is, p_rs, p_ic;
  assign p_rc = xr * pc;
  assign p_is = xi * ps;
  assign p_rs = xr * ps;
  assign p_ic = xi * pc;

  wire signed [AW-1:0] t_re = AW'(p_rc) - AW'(p_is);
  wire signed [AW-1:0] t_im = AW'(p_rs) + AW'(p_ic);
  wire signed [AW-1:0] nx_re = (b_i == '0 ? '0 : acc_re) + t_re;
  wire signed [AW-1:0] nx_im = (b_i == '0 ? '0 : acc_im) + t_im;
  wire signed [AW-1:0] sh_re = nx_re >>> SHIFT;
  wire signed [AW-1:0] sh_im = nx_im >>> SHIFT;

  always_ff @(posedge clk) begin
    if (take) begin
      lb_re[waddr] <= in_re;
      lb_im[waddr] <= in_im;
    end
    if (tbl_we) begin
      off_t[TW'(tbl_cell * BMAX + tbl_ap)] <= tbl_off;
      cos_t[TW'(tbl_cell * BMAX + tbl_ap)] <= tbl_cos;
      sin_t[TW'(tbl_cell * BMAX + tbl_ap)] <= tbl_sin;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; col <= '0; wptr <= '0; fill <= '0;
      l_i <= '0; b_i <= '0; acc_re <= '0; acc_im <= '0;
      out_valid <= 1'b0; out_last <= 1'b0; out_re <= '0; out_im <= '0;
    end else begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      if (flush) begin
        busy <= 1'b0; col <= '0; wptr <= '0; fill <= '0;
        l_i <= '0; b_i <= '0;
      end else if (busy) begin
        acc_re <= nx_re;
        acc_im <= nx_im;
        if (b_i == BW'(BMAX - 1)) begin
          b_i       <= '0;
          out_valid <= 1'b1;
          out_re    <= OW'(sh_re);
          out_im    <= OW'(sh_im);
          out_last  <= (l_i == CW'(NCELLS - 1));
          if (l_i == CW'(NCELLS - 1)) begin
            l_i  <= '0;
            busy <= 1'b0;
            wptr <= wnext;
          end else begin
            l_i <= l_i + 1'b1;
          end
        end else begin
          b_i <= b_i + 1'b1;
        end
      end else if (take) begin
        if (wcol == CW'(NCELLS - 1)) begin
          col <= '0;
          if (fill >= (BW+1)'(BMAX - 1)) begin
            fill <= (BW+1)'(BMAX);
            busy <= 1'b1;
          end else begin
            fill <= fill + 1'b1;
            wptr <= wnext;
          end
        end else begin
          col <= wcol + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sar_az_compressor_chk.sv
module sar_az_compressor_chk #(
  parameter int NCELLS = 8,
  parameter int BMAX   = 4
) (
  input logic clk,
  input logic rst_n,
  input logic flush,
  input logic in_valid,
  input logic in_ready,
  input logic out_valid,
  input logic out_last
);
  localparam int NS = NCELLS * BMAX;
  int unsigned n_acc;
  int unsigned n_beat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_acc  <= 0;
      n_beat <= 0;
    end else begin
      if (flush) n_acc <= 0;
      else if (in_valid && in_ready && n_acc < NS) n_acc <= n_acc + 1;
      if (out_valid) n_beat <= out_last ? 0 : n_beat + 1;
    end
  end

  AST_WARMUP_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> n_acc >= NS); // R1
  AST_LAST_ON_FINAL_CELL: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> (out_valid && n_beat == NCELLS - 1)); // R6
  AST_BEAT_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |-> n_beat < NCELLS - 1); // R6
  AST_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |-> !in_ready); // R7
  AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !out_valid); // R9
endmodule

bind sar_az_compressor sar_az_compressor_chk #(.NCELLS(NCELLS), .BMAX(BMAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
  .in_ready(in_ready), .out_valid(out_valid), .out_last(out_last));

// File: tb/test_sar_az_compressor.sv
module test_sar_az_compressor;
  localparam int NC = 8, BM = 4, OW = 16 + 16 + 2 + 2 - 15;

  logic clk = 0, rst_n = 0, flush = 0;
  logic tbl_we = 0;
  logic [2:0] tbl_cell = 0;
  logic [1:0] tbl_ap = 0;
  logic signed [3:0] tbl_off = 0;
  logic signed [15:0] tbl_cos = 0, tbl_sin = 0;
  logic in_valid = 0, in_sol = 0;
  logic signed [15:0] in_re = 0, in_im = 0;
  logic in_ready, out_valid, out_last;
  logic signed [OW-1:0] out_re, out_im;

  always #2.5 clk = ~clk;

  sar_az_compressor i_sar_az_compressor (
    .clk(clk), .rst_n(rst_n), .flush(flush), .tbl_we(tbl_we), .tbl_cell(tbl_cell),
    .tbl_ap(tbl_ap), .tbl_off(tbl_off), .tbl_cos(tbl_cos), .tbl_sin(tbl_sin),
    .in_valid(in_valid), .in_ready(in_ready), .in_sol(in_sol), .in_re(in_re),
    .in_im(in_im), .out_valid(out_valid), .out_last(out_last),
    .out_re(out_re), .out_im(out_im));

  // per pulse: echo cell, echo re, echo im
  localparam int VEC [6][3] = '{
    '{3, 9000, -4000}, '{4, -12000, 7000}, '{0, 15000, 15000},
    '{7, -20000, -3000}, '{5, 3000, 11000}, '{2, -32768, 32767}};

  int checks = 0, fails = 0;
  int hre [0:31][0:NC-1];
  int him [0:31][0:NC-1];
  int nl = 0;
  int cur_re [0:NC-1];
  int cur_im [0:NC-1];
  longint g_re [0:255];
  longint g_im [0:255];
  bit g_last [0:255];
  int ocnt = 0;

  always @(negedge clk) if (out_valid && ocnt < 256) begin
    g_re[ocnt] = out_re; g_im[ocnt] = out_im; g_last[ocnt] = out_last; ocnt = ocnt + 1;
  end

  function automatic int toff(int l, int b);
    if (b == 0 || b == 3) return 1;
    if (b == 1 && l == 0) return -1;
    return 0;
  endfunction
  function automatic int tcos(int b);
    case (b) 0: return 23170; 1: return 32767; 2: return 0; default: return -23170; endcase
  endfunction
  function automatic int tsin(int b);
    case (b) 0: return 23170; 1: return 0; 2: return -32768; default: return 23170; endcase
  endfunction

  function automatic longint model(int l, bit want_im);
    longint sr = 0, si = 0;
    for (int b = 0; b < BM; b++) begin
      int ix = l + toff(l, b);
      if (ix >= 0 && ix < NC) begin
        longint xr = hre[nl-1-b][ix], xi = him[nl-1-b][ix];
        sr += xr * tcos(b) - xi * tsin(b);
        si += xr * tsin(b) + xi * tcos(b);
      end
    end
    return want_im ? (si >>> 15) : (sr >>> 15);
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic make_line(int tgt, int er, int ei);
    for (int c = 0; c < NC; c++) begin
      cur_re[c] = (c == tgt) ? er : c * 37 - 100;
      cur_im[c] = (c == tgt) ? ei : 55 - c * 21;
    end
  endtask

  task automatic push_line();
    for (int c = 0; c < NC; c++) begin
      hre[nl][c] = cur_re[c]; him[nl][c] = cur_im[c];
    end
    nl++;
    for (int c = 0; c < NC; c++) begin
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1; in_sol = (c == 0); in_re = 16'(cur_re[c]); in_im = 16'(cur_im[c]);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 0; in_sol = 0;
  endtask

  task automatic wait_idle();
    repeat (2) @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_line(int base);
    int pk_g = 0, pk_e = 0;
    longint mg = -1, me = -1;
    bit lok = 1;
    chk(ocnt - base == NC, "R6 beat count", ocnt - base, NC);
    for (int c = 0; c < NC; c++) begin
      longint er = model(c, 0), ei = model(c, 1);
      longint ag = (g_re[base+c] < 0 ? -g_re[base+c] : g_re[base+c]) + (g_im[base+c] < 0 ? -g_im[base+c] : g_im[base+c]);
      longint ae = (er < 0 ? -er : er) + (ei < 0 ? -ei : ei);
      if (g_last[base+c] != (c == NC - 1)) lok = 0;
      chk(g_re[base+c] == er, (c == NC-1 || c == 0) ? "R3 edge re" : "R2 R4 R5 re", g_re[base+c], er);
      chk(g_im[base+c] == ei, "R2 R4 R5 im", g_im[base+c], ei);
      if (ag > mg) begin mg = ag; pk_g = c; end
      if (ae > me) begin me = ae; pk_e = c; end
    end
    chk(lok, "R6 last marker", lok, 1);
    chk(pk_g == pk_e, "R2 peak cell", pk_g, pk_e);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int base;
    #1;
    chk(in_ready == 1, "R10 ready", in_ready, 1);
    chk(out_valid == 0 && out_last == 0, "R10 valid", out_valid, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int l = 0; l < NC; l++)
      for (int b = 0; b < BM; b++) begin
        @(negedge clk);
        tbl_we = 1; tbl_cell = 3'(l); tbl_ap = 2'(b);
        tbl_off = 4'(toff(l, b)); tbl_cos = 16'(tcos(b)); tbl_sin = 16'(tsin(b));
      end
    @(negedge clk); tbl_we = 0;

    for (int i = 0; i < BM - 1; i++) begin
      make_line(i + 1, 5000 * (i + 1), -3000 * i);
      push_line();
      wait_idle();
      chk(ocnt == 0, "R1 warm-up silent", ocnt, 0);
    end

    for (int v = 0; v < 6; v++) begin
      make_line(VEC[v][0], VEC[v][1], VEC[v][2]);
      base = ocnt;
      push_line();
      chk(in_ready == 0, "R7 ready low in pass", in_ready, 0);
      in_valid = 1; in_re = 16'sd999; in_im = 16'sd999;
      wait_idle();
      in_valid = 0;
      check_line(base);
    end

    // R8: partial line then realign with start-of-line
    for (int c = 0; c < 3; c++) begin
      @(negedge clk); in_valid = 1; in_sol = (c == 0); in_re = 16'sd7777; in_im = -16'sd7777;
      @(posedge clk);
    end
    @(negedge clk); in_valid = 0; in_sol = 0;
    chk(ocnt == base + NC, "R8 no output from partial", ocnt, base + NC);
    make_line(6, 21000, -9000);
    base = ocnt;
    push_line();
    wait_idle();
    check_line(base);

    // R9: flush restarts warm-up
    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0;
    base = ocnt;
    for (int i = 0; i < BM - 1; i++) begin
      make_line(2 + i, -8000, 4000 * i);
      push_line();
      wait_idle();
    end
    chk(ocnt == base, "R9 silent after flush", ocnt, base);
    make_line(1, 12345, -23456);
    push_line();
    wait_idle();
    check_line(base);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule